// File: doc/BRIEF.md
# Main Oscillator Loss and Recovery Fallback Controller

This block supervises a main crystal clock using a free-running reference clock. Each edge of the main clock flips a toggle flag in the main domain. The flag is carried into the reference domain by a two-stage synchronizer, and there it becomes a one-cycle activity pulse.

Two counters judge that activity:
- A stop is declared after a run of reference cycles with no activity.
- A restart is declared once enough activity is counted inside a fixed window, while the clock is marked as stopped.

Either event sets a sticky detection flag, which drives a level interrupt. It also forces the backup oscillator on and updates the stopped status. A stop additionally sets a clock-source switch bit, but only in the operating modes that call for it. The CPU and peripheral clock-source selects are decoded from the operating mode and the switch bit. Software clears the detection flag, and may rewrite the switch bit and the backup-oscillator enable, through a one-cycle write port in the reference domain.

Reset (`rst_n`) is asynchronous and active low, and it applies to both clock domains. Each main-clock edge can only be counted if consecutive edges lie at least two reference periods apart. A faster main clock is still detected as running, but its edge count may alias.

Top module: `osc_fallback_ctrl`

## Requirements
- R1: After reset the detection flag, stopped status, switch bit and interrupt are 0, and the backup-oscillator enable is 1.
- R2: While `det_en` is 0, no stop or restart is declared, and the stopped status does not change.
- R3: With `det_en` at 1 and the stopped status at 0, a stop is declared after STOP_N (default 4) consecutive reference cycles without a synchronized main-clock edge. This holds even when the main clock still toggles, but too slowly.
- R4: A stop in high-speed mode (`mode`=0) or medium-speed mode (`mode`=1) does all of the following:
  - sets the detection flag and the stopped status;
  - sets the backup enable;
  - sets the switch bit, so `cpu_src` and `per_src` both select the backup clock.
- R5: A stop in low-speed mode (`mode`=2) sets the switch bit, but `cpu_src` stays on the subclock (2) while `per_src` moves to backup (1).
- R6: A stop in PLL mode (`mode`=4) sets the detection flag, the stopped status and the backup enable, and leaves the switch bit unchanged.
- R7: A stop in on-chip-oscillator mode (`mode`=3) sets the detection flag, the stopped status and the backup enable, and leaves the switch bit unchanged.
- R8: While the stopped status is 1, a restart is declared when RST_M (default 4) synchronized edges fall inside one window of WIN (default 12) reference cycles. A restart sets the detection flag, clears the stopped status, sets the backup enable, and leaves the switch bit unchanged. A main clock with too few edges per window does not restart.
- R9: The detection flag is sticky. Only a write with `wr_det`=0 clears it, and a write with `wr_det`=1 leaves it unchanged. A write also loads the switch bit from `wr_sw` and the backup enable from `wr_osc`.
- R10: `irq` equals the detection flag ANDed with `det_en`.
- R11: When a stop or restart falls in the same cycle as a write, the event's settings win for every field the event touches.
- R12: The source selects are encoded as follows.
  - `cpu_src`: 0 = main, 1 = backup, 2 = subclock, 3 = PLL.
  - `cpu_src` is 2 in low-speed mode and 1 in on-chip mode. In other modes it is 1 when the switch bit is set, otherwise 3 in PLL mode and 0 in all other modes.
  - `per_src`: 1 (backup) in on-chip mode or when the switch bit is set, else 0 (main).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| main_clk | input | 1 | Supervised main crystal clock |
| ref_clk | input | 1 | Free-running reference clock; all state except the toggle flag lives here |
| rst_n | input | 1 | Asynchronous active-low reset |
| det_en | input | 1 | Enables detection and its side effects |
| mode | input | 3 | Operating mode: 0 high, 1 medium, 2 low, 3 on-chip, 4 PLL (5-7 act as high) |
| wr_en | input | 1 | One-cycle software write strobe |
| wr_det | input | 1 | Write value for the detection flag (0 clears, 1 keeps) |
| wr_sw | input | 1 | Write value for the switch bit |
| wr_osc | input | 1 | Write value for the backup-oscillator enable |
| irq | output | 1 | Level interrupt |
| det_flag | output | 1 | Sticky stop/restart detection flag |
| stopped_flag | output | 1 | 1 while the main clock is considered stopped |
| osc_en | output | 1 | Backup oscillator enable |
| sw_bit | output | 1 | Clock-source switch bit |
| cpu_src | output | 2 | CPU clock-source select |
| per_src | output | 1 | Peripheral clock-source select |

## Verification
A stop declaration and a software write can land in the same reference cycle, and both drive the detection flag, the backup enable and the switch bit. The bench halts the main clock in high-speed mode and then issues one all-zero write. The write is delayed by 0 to 11 cycles on successive passes, so that one pass meets the declaration cycle itself. After each pass the triple {detection, enable, switch} must read as either all ones (the event won or came last) or all zeros (the write came after). Any mixed result is a failure, and the sweep must show both outcomes.

// File: rtl/fb_pkg.sv
`timescale 1ns/1ps
package fb_pkg;

  localparam logic [2:0] MODE_HIGH = 3'd0;
  localparam logic [2:0] MODE_MED  = 3'd1;
  localparam logic [2:0] MODE_LOW  = 3'd2;
  localparam logic [2:0] MODE_OCO  = 3'd3;
  localparam logic [2:0] MODE_PLL  = 3'd4;

  typedef enum logic [1:0] {
    CPU_MAIN   = 2'd0,
    CPU_BACKUP = 2'd1,
    CPU_SUB    = 2'd2,
    CPU_PLL    = 2'd3
  } cpu_src_e;

  // Modes in which a declared stop sets the switch bit
  function automatic logic stop_sets_switch(input logic [2:0] m);
    case (m)
      MODE_OCO, MODE_PLL: return 1'b0;
      default:            return 1'b1;
    endcase
  endfunction

  function automatic cpu_src_e cpu_select(input logic [2:0] m, input logic sw);
    if (m == MODE_LOW)      return CPU_SUB;
    else if (m == MODE_OCO) return CPU_BACKUP;
    else if (sw)            return CPU_BACKUP;
    else if (m == MODE_PLL) return CPU_PLL;
    else                    return CPU_MAIN;
  endfunction

  function automatic logic per_select(input logic [2:0] m, input logic sw);
    return (m == MODE_OCO) || sw;
  endfunction

endpackage

// File: rtl/fb_edge_sync.sv
`timescale 1ns/1ps
module fb_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic main_clk,
  input  logic ref_clk,
  input  logic rst_n,
  output logic edge_seen
);
  localparam int QW = SYNC_STAGES + 1;

  logic           tgl;
  logic [QW-1:0]  q;

  always_ff @(posedge main_clk or negedge rst_n) begin
    if (!rst_n) tgl <= 1'b0;
    else        tgl <= ~tgl;
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= {q[QW-2:0], tgl};
  end

  assign edge_seen = q[QW-1] ^ q[QW-2];
endmodule

// File: rtl/fb_activity_mon.sv
`timescale 1ns/1ps
module fb_activity_mon #(
  parameter int STOP_N = 4,
  parameter int RST_M  = 4,
  parameter int WIN    = 12
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic en,
  input  logic edge_seen,
  input  logic stopped,
  output logic stop_evt,
  output logic restart_evt
);
  localparam int IW = $clog2(STOP_N + 1);
  localparam int WW = $clog2(WIN);
  localparam int EW = $clog2(RST_M + 1);

  logic [IW-1:0] idle_cnt;
  logic [WW-1:0] win_cnt;
  logic [EW-1:0] edge_cnt;
  logic          win_last;

  assign win_last = (win_cnt == WW'(WIN - 1));

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_cnt <= '0;
    end else if (!en || edge_seen) begin
      idle_cnt <= '0;
    end else if (idle_cnt != IW'(STOP_N)) begin
      idle_cnt <= idle_cnt + 1'b1;
    end
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt  <= '0;
      edge_cnt <= '0;
    end else if (!en || win_last) begin
      win_cnt  <= '0;
      edge_cnt <= '0;
    end else begin
      win_cnt <= win_cnt + 1'b1;
      if (edge_seen && edge_cnt != EW'(RST_M))
        edge_cnt <= edge_cnt + 1'b1;
    end
  end

  assign stop_evt    = en && !stopped && !edge_seen && (idle_cnt == IW'(STOP_N - 1));
  assign restart_evt = en &&  stopped &&  edge_seen && (edge_cnt == EW'(RST_M - 1));
endmodule

// File: rtl/fb_status_regs.sv
`timescale 1ns/1ps
module fb_status_regs (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic stop_evt,
  input  logic restart_evt,
  input  logic sets_switch,
  input  logic wr_en,
  input  logic wr_det,
  input  logic wr_sw,
  input  logic wr_osc,
  output logic det_q,
  output logic stopped_q,
  output logic sw_q,
  output logic osc_q
);
  logic any_evt;
  assign any_evt = stop_evt || restart_evt;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      det_q     <= 1'b0;
      stopped_q <= 1'b0;
      sw_q      <= 1'b0;
      osc_q     <= 1'b1;
    end else begin
      if (any_evt)               det_q <= 1'b1;
      else if (wr_en && !wr_det) det_q <= 1'b0;

      if (stop_evt)         stopped_q <= 1'b1;
      else if (restart_evt) stopped_q <= 1'b0;

      if (any_evt)    osc_q <= 1'b1;
      else if (wr_en) osc_q <= wr_osc;

      if (stop_evt && sets_switch) sw_q <= 1'b1;
      else if (wr_en)              sw_q <= wr_sw;
    end
  end
endmodule

// File: rtl/osc_fallback_ctrl.sv
`timescale 1ns/1ps
module osc_fallback_ctrl #(
  parameter int STOP_N      = 4,
  parameter int RST_M       = 4,
  parameter int WIN         = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic       main_clk,
  input  logic       ref_clk,
  input  logic       rst_n,
  input  logic       det_en,
  input  logic [2:0] mode,
  input  logic       wr_en,
  input  logic       wr_det,
  input  logic       wr_sw,
  input  logic       wr_osc,
  output logic       irq,
  output logic       det_flag,
  output logic       stopped_flag,
  output logic       osc_en,
  output logic       sw_bit,
  output logic [1:0] cpu_src,
  output logic       per_src
);
  import fb_pkg::*;

  logic edge_seen;
  logic stop_evt;
  logic restart_evt;
  logic sets_switch;

  fb_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .main_clk (main_clk),
    .ref_clk  (ref_clk),
    .rst_n    (rst_n),
    .edge_seen(edge_seen)
  );

  fb_activity_mon #(.STOP_N(STOP_N), .RST_M(RST_M), .WIN(WIN)) u_mon (
    .ref_clk    (ref_clk),
    .rst_n      (rst_n),
    .en         (det_en),
    .edge_seen  (edge_seen),
    .stopped    (stopped_flag),
    .stop_evt   (stop_evt),
    .restart_evt(restart_evt)
  );

  assign sets_switch = stop_sets_switch(mode);

  fb_status_regs u_regs (
    .ref_clk    (ref_clk),
    .rst_n      (rst_n),
    .stop_evt   (stop_evt),
    .restart_evt(restart_evt),
    .sets_switch(sets_switch),
    .wr_en      (wr_en),
    .wr_det     (wr_det),
    .wr_sw      (wr_sw),
    .wr_osc     (wr_osc),
    .det_q      (det_flag),
    .stopped_q  (stopped_flag),
    .sw_q       (sw_bit),
    .osc_q      (osc_en)
  );

  assign irq     = det_flag & det_en;
  assign cpu_src = cpu_select(mode, sw_bit);
  assign per_src = per_select(mode, sw_bit);
endmodule

// File: rtl/fb_chk.sv
`timescale 1ns/1ps
module fb_chk (
  input logic       ref_clk,
  input logic       rst_n,
  input logic       det_en,
  input logic [2:0] mode,
  input logic       wr_en,
  input logic       wr_det,
  input logic       stop_evt,
  input logic       restart_evt,
  input logic       det_flag,
  input logic       stopped_flag,
  input logic       osc_en,
  input logic       sw_bit,
  input logic [1:0] cpu_src
);
  // R2
  idle_when_off_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !det_en |=> $stable(stopped_flag));

  // R3
  stop_marks_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    stop_evt |=> stopped_flag && det_flag && osc_en);

  // R4
  fast_mode_switch_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    stop_evt && (mode == 3'd0 || mode == 3'd1) |=> sw_bit);

  // R6
  pll_keeps_switch_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    stop_evt && mode == 3'd4 && !wr_en |=> $stable(sw_bit));

  // R8
  restart_marks_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    restart_evt |=> !stopped_flag && det_flag && osc_en);

  // R9
  det_sticky_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    det_flag && !(wr_en && !wr_det) |=> det_flag);

  // R11
  event_beats_write_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (stop_evt || restart_evt) && wr_en |=> det_flag && osc_en);

  // R12
  sub_only_low_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    cpu_src == 2'd2 |-> mode == 3'd2);
endmodule

bind osc_fallback_ctrl fb_chk u_chk (
  .ref_clk     (ref_clk),
  .rst_n       (rst_n),
  .det_en      (det_en),
  .mode        (mode),
  .wr_en       (wr_en),
  .wr_det      (wr_det),
  .stop_evt    (stop_evt),
  .restart_evt (restart_evt),
  .det_flag    (det_flag),
  .stopped_flag(stopped_flag),
  .osc_en      (osc_en),
  .sw_bit      (sw_bit),
  .cpu_src     (cpu_src)
);

// File: tb/osc_fallback_ctrl_tb.sv
`timescale 1ns/1ps
module osc_fallback_ctrl_tb;
  localparam int REF_PERIOD = 10;

  logic main_clk = 1'b0, ref_clk = 1'b0, rst_n = 1'b0;
  logic det_en = 1'b0, wr_en = 1'b0, wr_det = 1'b1, wr_sw = 1'b0, wr_osc = 1'b0;
  logic [2:0] mode = 3'd0;
  logic irq, det_flag, stopped_flag, osc_en, sw_bit, per_src;
  logic [1:0] cpu_src;

  int  total = 0, bad = 0;
  int  main_half = 10;
  bit  main_run = 1'b1;
  bit  e_det = 0, e_stop = 0, e_sw = 0, e_osc = 1;

  osc_fallback_ctrl u_dut (
    .main_clk(main_clk), .ref_clk(ref_clk), .rst_n(rst_n), .det_en(det_en),
    .mode(mode), .wr_en(wr_en), .wr_det(wr_det), .wr_sw(wr_sw), .wr_osc(wr_osc),
    .irq(irq), .det_flag(det_flag), .stopped_flag(stopped_flag), .osc_en(osc_en),
    .sw_bit(sw_bit), .cpu_src(cpu_src), .per_src(per_src)
  );

  initial forever #(REF_PERIOD / 2) ref_clk = ~ref_clk;
  initial forever begin
    #(main_half);
    if (main_run) main_clk = ~main_clk;
  end

  function automatic bit b_sets(input logic [2:0] m);
    return (m == 3'd0) || (m == 3'd1) || (m == 3'd2);
  endfunction

  function automatic int b_cpu(input logic [2:0] m, input bit sw);
    case (m)
      3'd2:    return 2;
      3'd3:    return 1;
      3'd4:    return sw ? 1 : 3;
      default: return sw ? 1 : 0;
    endcase
  endfunction

  function automatic int b_per(input logic [2:0] m, input bit sw);
    return (sw || m == 3'd3) ? 1 : 0;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic check_all(input string req);
    check({req, " det"},     det_flag,     e_det);
    check({req, " stopped"}, stopped_flag, e_stop);
    check({req, " sw"},      sw_bit,       e_sw);
    check({req, " osc"},     osc_en,       e_osc);
    check({req, " irq R10"}, irq,          e_det & det_en);
    check({req, " cpu R12"}, cpu_src,      b_cpu(mode, e_sw));
    check({req, " per R12"}, per_src,      b_per(mode, e_sw));
  endtask

  task automatic wr(input bit d, input bit s, input bit o);
    @(negedge ref_clk);
    wr_en = 1'b1; wr_det = d; wr_sw = s; wr_osc = o;
    @(negedge ref_clk);
    wr_en = 1'b0;
    if (!d) e_det = 0;
    e_sw = s; e_osc = o;
  endtask

  task automatic halt_main();
    main_run = 1'b0;
    ticks(20);
    if (det_en && !e_stop) begin
      e_det = 1; e_stop = 1; e_osc = 1;
      if (b_sets(mode)) e_sw = 1;
    end
  endtask

  task automatic resume_main();
    main_half = 10;
    main_run = 1'b1;
    ticks(40);
    if (det_en && e_stop) begin
      e_det = 1; e_stop = 0; e_osc = 1;
    end
  endtask

  task automatic mode_case(input logic [2:0] m, input string req);
    det_en = 1'b1; mode = m;
    wr(1'b0, 1'b0, 1'b0);
    ticks(2);
    check_all({req, " pre"});
    halt_main();
    check_all(req);
    resume_main();
    check_all("R8");
  endtask

  initial begin
    #(REF_PERIOD * 200000);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0F1C));
    ticks(5);
    rst_n = 1'b1;
    ticks(3);
    check_all("R1");

    // R2: detection off, main clock halts, nothing moves
    halt_main();
    check_all("R2");
    resume_main();

    // R3: not declared early, declared later
    det_en = 1'b1; mode = 3'd0;
    ticks(3);
    main_run = 1'b0;
    ticks(2);
    check("R3 early", stopped_flag, 0);
    ticks(18);
    e_det = 1; e_stop = 1; e_osc = 1; e_sw = 1;
    check_all("R3");
    resume_main();
    check_all("R8 fast");
    wr(1'b0, 1'b0, 1'b0);

    // R3/R8: slow main clock is stopped and not restarted
    main_half = 35;
    ticks(40);
    e_det = 1; e_stop = 1; e_osc = 1; e_sw = 1;
    check_all("R3 slow");
    wr(1'b0, 1'b0, 1'b0);
    ticks(60);
    check_all("R8 slow");
    resume_main();
    check_all("R8");

    // Directed per-mode stops
    mode_case(3'd0, "R4 high");
    mode_case(3'd1, "R4 med");
    mode_case(3'd2, "R5 low");
    mode_case(3'd4, "R6 pll");
    mode_case(3'd3, "R7 oco");

    // R9: writing 1 keeps the flag, writing 0 clears it
    wr(1'b1, 1'b0, 1'b1);
    ticks(3);
    check_all("R9 keep");
    // R10: flag set but detection off
    det_en = 1'b0;
    ticks(1);
    check("R10 masked", irq, 0);
    check("R10 det held", det_flag, 1);
    det_en = 1'b1;
    wr(1'b0, 1'b0, 1'b1);
    ticks(3);
    check_all("R9 clear");

    // R11: sweep a write across the stop declaration
    begin
      bit saw_evt = 0, saw_wr = 0;
      mode = 3'd0;
      for (int k = 0; k < 12; k++) begin
        wr(1'b0, 1'b0, 1'b0);
        main_run = 1'b0;
        ticks(k);
        wr(1'b0, 1'b0, 1'b0);
        ticks(20);
        check("R11 stopped", stopped_flag, 1);
        if ({det_flag, osc_en, sw_bit} == 3'b111) saw_evt = 1;
        else if ({det_flag, osc_en, sw_bit} == 3'b000) saw_wr = 1;
        else check("R11 mixed", {det_flag, osc_en, sw_bit}, 7);
        e_stop = 1;
        resume_main();
      end
      check("R11 both outcomes", saw_evt && saw_wr, 1);
    end
    wr(1'b0, 1'b0, 1'b1);
    ticks(2);
    check_all("R9 after sweep");

    // Random mix
    for (int it = 0; it < 40; it++) begin
      logic [2:0] m;
      bit en, s, o;
      m  = 3'($urandom % 5);
      en = ($urandom % 4) != 0;
      s  = 1'($urandom % 2);
      o  = 1'($urandom % 2);
      det_en = en; mode = m;
      wr(1'b0, s, o);
      ticks(2);
      check_all("R12 rand");
      halt_main();
      check_all(b_sets(m) ? "R4 rand" : "R6 rand");
      wr(1'b1, 1'($urandom % 2), 1'b0);
      ticks(1);
      check_all("R9 rand");
      resume_main();
      check_all("R8 rand");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule